// File: doc/BRIEF.md
# Zero-Crossing Synchronised Mute Controller

This block decides, for each of two audio channels, whether the channel's mute switch is closed. Software supplies two held bits (a general mute request and a zero-crossing mode select) plus a one-cycle strobe each time the switch register is written. An active-low hardware mute pin and one "sample is near zero" flag per channel complete the inputs. The block drives one mute enable per channel.

With zero-crossing mode off, the general mute request reaches both channels on the next clock edge. With the mode on, each channel keeps its old mute state until its own signal crosses zero. This applies to both muting and unmuting, so no step is switched into the audio. A crossing is taken as the rising edge of the channel's in-window flag. A timeout counter bounds the wait. It is reloaded by every switch-register strobe and rests at zero when idle. Once it has run out, the channel takes the requested state anyway.

The hardware pin overrides everything while it is low. It is never stored: after the pin returns high, the outputs stay muted for a short release interval. They then show whatever state the bus control has reached in the meantime.

Top module: `zcm_mute_top`

## Requirements
- R1: After reset, both mute outputs are 1.
- R2: With zero-crossing mode 0, each channel's bus mute state equals the general mute bit from the previous clock edge.
- R3: With zero-crossing mode 1 and the timeout running, a change of the general mute bit, whether to 1 or to 0, does not reach a channel until that channel's next crossing.
- R4: Each channel switches only at its own crossing. A crossing on one channel leaves the other channel unchanged.
- R5: A crossing is a 0-to-1 transition of the channel's in-window flag between two consecutive edges. A flag held at 1, or a 1-to-0 transition, causes no switching.
- R6: A switch-register strobe reloads the timeout with TIMEOUT_CYCLES. If no crossing occurs, the channel takes the general mute bit on the edge TIMEOUT_CYCLES+1 edges after the strobe edge. A later strobe restarts this window.
- R7: When the timeout has run out (its idle state), a change of the general mute bit with zero-crossing mode 1 and no strobe reaches both channels on the next edge.
- R8: While the hardware mute pin is 0, both mute outputs are 1 in the same cycle, with no clock edge needed.
- R9: After the hardware pin returns to 1, the outputs stay 1 for RELEASE_CYCLES edges, counted from the first edge that samples the pin at 1. They then show the bus mute state, which kept tracking the bus inputs while the pin was low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| genMute | input | 1 | General mute request from the switch register |
| zcMode | input | 1 | 1 = defer mute changes to a zero crossing |
| swWrite | input | 1 | One-cycle strobe on each switch-register write |
| hwMuteN | input | 1 | Active-low hardware mute pin |
| inWindow | input | NUM_CH | Per-channel flag: sample lies within the zero window |
| muteOut | output | NUM_CH | Per-channel mute enable (1 = muted) |

## Verification
On every cycle, the assertions check the following:
- the hardware override of both outputs;
- that outputs are still muted on the first cycle after the pin releases;
- one-edge tracking of the request when zero-crossing mode is off;
- that a deferred channel holds still while its timeout runs and it sees no crossing;
- the timeout reload on each strobe;
- the muted state right after reset.

Only the bench's scenarios can show the rest. These are the exact edge on which a timeout forces the change, the restart of the window by a second strobe, and the fact that a flag held high does not retrigger. They also cover deferred unmuting as well as muting, and the return to the bus state after the release interval.

// File: rtl/zcm_pkg.sv
package zcm_pkg;

  // Strobes from the control section to the per-channel datapath.
  typedef struct packed {
    logic applyAll;   // every channel may take the requested state this edge
    logic forceMute;  // hardware override or its release tail is active
  } zcmStrobe_t;

endpackage

// File: rtl/zcm_timeout.sv
module zcm_timeout #(
  parameter int TIMEOUT_CYCLES = 25_000_000
) (
  input  logic clk,
  input  logic rstN,
  input  logic swWrite,
  output logic timerIdle
);
  localparam int CNT_W = $clog2(TIMEOUT_CYCLES + 1);

  logic [CNT_W-1:0] remain;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      remain <= '0;
    end else if (swWrite) begin
      remain <= CNT_W'(TIMEOUT_CYCLES);
    end else if (remain != '0) begin
      remain <= remain - 1'b1;
    end
  end

  assign timerIdle = (remain == '0);
endmodule

// File: rtl/zcm_release.sv
module zcm_release #(
  parameter int RELEASE_CYCLES = 125_000
) (
  input  logic clk,
  input  logic rstN,
  input  logic hwMuteN,
  output logic holdMute
);
  localparam int REL_W = $clog2(RELEASE_CYCLES + 1);

  logic [REL_W-1:0] tail;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tail <= '0;
    end else if (!hwMuteN) begin
      tail <= REL_W'(RELEASE_CYCLES);
    end else if (tail != '0) begin
      tail <= tail - 1'b1;
    end
  end

  assign holdMute = !hwMuteN || (tail != '0);
endmodule

// File: rtl/zcm_ctrl.sv
module zcm_ctrl
  import zcm_pkg::*;
#(
  parameter int TIMEOUT_CYCLES = 25_000_000,
  parameter int RELEASE_CYCLES = 125_000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       zcMode,
  input  logic       swWrite,
  input  logic       hwMuteN,
  output logic       timerIdle,
  output zcmStrobe_t strobe
);
  logic holdMute;

  zcm_timeout #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) uTimeout (
    .clk      (clk),
    .rstN     (rstN),
    .swWrite  (swWrite),
    .timerIdle(timerIdle)
  );

  zcm_release #(.RELEASE_CYCLES(RELEASE_CYCLES)) uRelease (
    .clk     (clk),
    .rstN    (rstN),
    .hwMuteN (hwMuteN),
    .holdMute(holdMute)
  );

  // A strobe in this cycle reloads the timer, so an idle timer must not
  // let the freshly written request through on the same edge.
  always_comb begin
    strobe.applyAll  = !zcMode || (timerIdle && !swWrite);
    strobe.forceMute = holdMute;
  end
endmodule

// File: rtl/zcm_lane.sv
module zcm_lane
  import zcm_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       genMute,
  input  logic       inWindow,
  input  zcmStrobe_t strobe,
  output logic       crossing,
  output logic       busMute,
  output logic       muteOut
);
  logic prevWin;

  assign crossing = inWindow && !prevWin;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevWin <= 1'b1;
      busMute <= 1'b1;
    end else begin
      prevWin <= inWindow;
      if (strobe.applyAll || crossing) begin
        busMute <= genMute;
      end
    end
  end

  assign muteOut = busMute || strobe.forceMute;
endmodule

// File: rtl/zcm_datapath.sv
module zcm_datapath
  import zcm_pkg::*;
#(
  parameter int NUM_CH = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              genMute,
  input  logic [NUM_CH-1:0] inWindow,
  input  zcmStrobe_t        strobe,
  output logic [NUM_CH-1:0] crossing,
  output logic [NUM_CH-1:0] busState,
  output logic [NUM_CH-1:0] muteOut
);
  for (genvar ch = 0; ch < NUM_CH; ch++) begin : gLane
    zcm_lane uLane (
      .clk     (clk),
      .rstN    (rstN),
      .genMute (genMute),
      .inWindow(inWindow[ch]),
      .strobe  (strobe),
      .crossing(crossing[ch]),
      .busMute (busState[ch]),
      .muteOut (muteOut[ch])
    );
  end
endmodule

// File: rtl/zcm_mute_top.sv
module zcm_mute_top
  import zcm_pkg::*;
#(
  parameter int NUM_CH         = 2,
  parameter int TIMEOUT_CYCLES = 25_000_000,
  parameter int RELEASE_CYCLES = 125_000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              genMute,
  input  logic              zcMode,
  input  logic              swWrite,
  input  logic              hwMuteN,
  input  logic [NUM_CH-1:0] inWindow,
  output logic [NUM_CH-1:0] muteOut
);
  zcmStrobe_t        strobe;
  logic              timerIdle;
  logic [NUM_CH-1:0] crossing;
  logic [NUM_CH-1:0] busState;

  zcm_ctrl #(
    .TIMEOUT_CYCLES(TIMEOUT_CYCLES),
    .RELEASE_CYCLES(RELEASE_CYCLES)
  ) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .zcMode   (zcMode),
    .swWrite  (swWrite),
    .hwMuteN  (hwMuteN),
    .timerIdle(timerIdle),
    .strobe   (strobe)
  );

  zcm_datapath #(.NUM_CH(NUM_CH)) uData (
    .clk     (clk),
    .rstN    (rstN),
    .genMute (genMute),
    .inWindow(inWindow),
    .strobe  (strobe),
    .crossing(crossing),
    .busState(busState),
    .muteOut (muteOut)
  );
endmodule

// File: rtl/zcm_mute_checker.sv
module zcm_mute_checker #(
  parameter int NUM_CH = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              genMute,
  input logic              zcMode,
  input logic              swWrite,
  input logic              hwMuteN,
  input logic              timerIdle,
  input logic [NUM_CH-1:0] crossing,
  input logic [NUM_CH-1:0] busState,
  input logic [NUM_CH-1:0] muteOut
);
  AST_RESET_MUTED: assert property (@(posedge clk)
    $rose(rstN) |-> (&muteOut));  // R1

  AST_DIRECT_FOLLOW: assert property (@(posedge clk) disable iff (!rstN)
    !zcMode |=> (busState == {NUM_CH{$past(genMute)}}));  // R2

  AST_DEFER_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (zcMode && (swWrite || !timerIdle) && (crossing == '0)) |=> $stable(busState));  // R3

  AST_LANE_SEPARATE: assert property (@(posedge clk) disable iff (!rstN)
    (zcMode && (swWrite || !timerIdle) && crossing[0] && !crossing[NUM_CH-1])
      |=> (busState[NUM_CH-1] == $past(busState[NUM_CH-1])));  // R4

  AST_RELOAD_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    swWrite |=> !timerIdle);  // R6

  AST_HW_OVERRIDE: assert property (@(posedge clk) disable iff (!rstN)
    !hwMuteN |-> (&muteOut));  // R8

  AST_RELEASE_TAIL: assert property (@(posedge clk) disable iff (!rstN)
    $rose(hwMuteN) |-> (&muteOut));  // R9
endmodule

bind zcm_mute_top zcm_mute_checker #(.NUM_CH(NUM_CH)) uChecker (
  .clk      (clk),
  .rstN     (rstN),
  .genMute  (genMute),
  .zcMode   (zcMode),
  .swWrite  (swWrite),
  .hwMuteN  (hwMuteN),
  .timerIdle(timerIdle),
  .crossing (crossing),
  .busState (busState),
  .muteOut  (muteOut)
);

// File: tb/tb_zcm_mute_top.sv
`timescale 1ns/1ps
module tb_zcm_mute_top;
  localparam int NCH = 2;
  localparam int TOUT = 64;
  localparam int REL = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic genMute = 1'b0;
  logic zcMode = 1'b0;
  logic swWrite = 1'b0;
  logic hwMuteN = 1'b1;
  logic [NCH-1:0] inWindow = '0;
  logic [NCH-1:0] muteOut;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  zcm_mute_top #(
    .NUM_CH(NCH), .TIMEOUT_CYCLES(TOUT), .RELEASE_CYCLES(REL)
  ) dut (
    .clk(clk), .rstN(rstN), .genMute(genMute), .zcMode(zcMode),
    .swWrite(swWrite), .hwMuteN(hwMuteN), .inWindow(inWindow),
    .muteOut(muteOut)
  );

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic expect_mute(input logic [NCH-1:0] exp, input string tag);
    checks++;
    if (muteOut !== exp) begin
      failures++;
      $display("FAIL %s: muteOut=%b expected=%b at %0t", tag, muteOut, exp, $time);
    end
  endtask

  // Write the switch register: request value plus a one-cycle strobe.
  task automatic sw_write(input logic val);
    genMute = val;
    swWrite = 1'b1;
    step(1);
    swWrite = 1'b0;
  endtask

  task automatic t_reset();
    rstN = 1'b0;
    step(3);
    expect_mute(2'b11, "R1 muted in reset");
    zcMode = 1'b1;
    genMute = 1'b0;
    rstN = 1'b1;
    #0.5;
    expect_mute(2'b11, "R1 muted right after reset");
  endtask

  task automatic t_direct();
    zcMode = 1'b0;
    genMute = 1'b0;
    step(1);
    expect_mute(2'b00, "R2 direct unmute");
    genMute = 1'b1;
    step(1);
    expect_mute(2'b11, "R2 direct mute");
    genMute = 1'b0;
    step(1);
    expect_mute(2'b00, "R2 direct unmute again");
  endtask

  task automatic t_zc_defer();
    zcMode = 1'b1;
    inWindow = 2'b00;
    sw_write(1'b1);
    step(2);
    expect_mute(2'b00, "R3 mute deferred without crossing");
    inWindow[0] = 1'b1;
    step(1);
    expect_mute(2'b01, "R4 ch0 mutes at its own crossing only");
    step(3);
    expect_mute(2'b01, "R5 held flag does not retrigger ch1");
    inWindow[1] = 1'b1;
    step(1);
    expect_mute(2'b11, "R4 ch1 mutes at its crossing");
    sw_write(1'b0);
    inWindow = 2'b00;
    step(1);
    expect_mute(2'b11, "R5 falling flag is no crossing");
    inWindow[0] = 1'b1;
    step(1);
    expect_mute(2'b10, "R3 unmute at ch0 crossing");
    inWindow[1] = 1'b1;
    step(1);
    expect_mute(2'b00, "R3 unmute at ch1 crossing");
    inWindow = 2'b00;
    step(TOUT + 2);
  endtask

  task automatic t_timeout();
    zcMode = 1'b1;
    inWindow = 2'b00;
    sw_write(1'b1);
    step(TOUT);
    expect_mute(2'b00, "R6 still pending on last timeout edge");
    step(1);
    expect_mute(2'b11, "R6 forced after timeout");
    sw_write(1'b0);
    step(TOUT / 2);
    sw_write(1'b0);
    step(TOUT);
    expect_mute(2'b11, "R6 second strobe restarts window");
    step(1);
    expect_mute(2'b00, "R6 forced after restarted window");
  endtask

  task automatic t_idle();
    zcMode = 1'b1;
    step(2);
    genMute = 1'b1;
    step(1);
    expect_mute(2'b11, "R7 idle timer applies at once");
    genMute = 1'b0;
    step(1);
    expect_mute(2'b00, "R7 idle timer applies unmute");
  endtask

  task automatic t_hw();
    zcMode = 1'b0;
    genMute = 1'b0;
    step(1);
    hwMuteN = 1'b0;
    #0.5;
    expect_mute(2'b11, "R8 pin low mutes without edge");
    genMute = 1'b1;
    step(2);
    genMute = 1'b0;
    step(2);
    expect_mute(2'b11, "R8 held while pin low");
    hwMuteN = 1'b1;
    #0.5;
    expect_mute(2'b11, "R9 muted just after release");
    step(REL - 1);
    expect_mute(2'b11, "R9 muted within release tail");
    step(1);
    expect_mute(2'b00, "R9 returns to bus state, pin not stored");
  endtask

  initial begin
    step(1);
    t_reset();
    t_direct();
    t_zc_defer();
    t_timeout();
    t_idle();
    t_hw();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule